// File: doc/BRIEF.md
# Array-DLL Hit Code to Binary Time Encoder

This block turns a raw interpolator hit code into a plain binary time word. The interpolator is an array of `DLL_F` timing delay lines of `TAPS_N` taps each, staggered against one another by a phase-shifting delay line. A hit is described by the index of the timing line that caught it, the tap index inside that line, and the count of whole reference clock periods. The reference period splits into `TAPS_N*DLL_F` bins, which is usually not a power of two, so the fields cannot simply be concatenated.

The encoder first reorders the (line, tap) pair into a bin number from 0 to `TAPS_N*DLL_F-1`. It then scales the period count by the bin count and adds the bin number. A hit strobe qualifies each code. The block takes one hit per clock, and results come out of a two-stage pipeline with a valid flag that travels alongside. Codes whose line or tap index is out of range raise an error flag in place of a result. The default set is 35 taps and 4 lines, which gives 140 bins per period.

Top module: `tdc_fine_encoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `time_vld` and `time_err` are 0 and `time_word` is 0.
- R2: For a valid in-range hit with line index k and tap index i, the fine part of the result is (i*DLL_F + k*(DLL_F+1)) mod (TAPS_N*DLL_F).
- R3: Over all TAPS_N*DLL_F in-range (k, i) pairs, the fine parts are pairwise distinct and cover every value from 0 to TAPS_N*DLL_F-1.
- R4: `time_word` equals `hit_coarse`*(TAPS_N*DLL_F) plus the fine part, with no truncation for any coarse value, the all-ones value included.
- R5: A strobed hit sampled at a rising edge produces its result at the second rising edge after it, with `time_vld` high for exactly that one cycle.
- R6: Hits on consecutive cycles each yield their own result on consecutive cycles, in order, with none dropped.
- R7: A strobed hit with k >= DLL_F or i >= TAPS_N raises `time_err` for one cycle at the same latency as a result, keeps `time_vld` low, and leaves `time_word` unchanged.
- R8: A cycle with `hit_vld` low yields `time_vld` and `time_err` low two cycles later and leaves `time_word` unchanged, whatever the code inputs carry.
- R9: R2 to R8 hold for a second parameter set with 15 taps and 2 lines (30 bins per period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hit_vld | input | 1 | Hit strobe qualifying the code inputs |
| hit_dll | input | K_W | Timing delay line index k |
| hit_tap | input | I_W | Tap index i inside that line |
| hit_coarse | input | COARSE_W | Whole reference periods elapsed |
| time_vld | output | 1 | One-cycle pulse marking a fresh result |
| time_err | output | 1 | One-cycle pulse marking an out-of-range code |
| time_word | output | COARSE_W+FINE_W | Binary time in bins of one period/(TAPS_N*DLL_F) |

## Verification
Every outcome of a strobe sampled at a rising edge (result, error pulse, or quiet cycle) is due at the second rising edge after it. The bench keeps a two-slot delay model per instance and compares all three outputs at each falling edge, which is half a cycle after the register updates. That way a result that arrives a cycle early or late shows up as a mismatch on the cycle it should have appeared. The held word is tracked in the model, so the no-update cases for faults and idle cycles are checked on the port itself.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

    typedef enum logic [1:0] {
        HK_IDLE  = 2'd0,
        HK_HIT   = 2'd1,
        HK_FAULT = 2'd2
    } hit_kind_e;

    function automatic int unsigned bins_per_period(input int unsigned taps, input int unsigned lines);
        return taps * lines;
    endfunction

endpackage

// File: rtl/tdc_enc_bin_map.sv
module tdc_enc_bin_map
    import tdc_enc_pkg::*;
#(
    parameter int TAPS_N   = 35,
    parameter int DLL_F    = 4,
    parameter int K_W      = 3,
    parameter int I_W      = 7,
    parameter int COARSE_W = 12,
    parameter int FINE_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [K_W-1:0]      in_dll,
    input  logic [I_W-1:0]      in_tap,
    input  logic [COARSE_W-1:0] in_coarse,
    output hit_kind_e           s1_kind,
    output logic [FINE_W-1:0]   s1_fine,
    output logic [COARSE_W-1:0] s1_coarse
);
    localparam int BINS  = int'(bins_per_period(TAPS_N, DLL_F));
    localparam int SUM_W = FINE_W + 1;
    localparam logic [K_W-1:0]   K_LIM  = K_W'(DLL_F);
    localparam logic [I_W-1:0]   I_LIM  = I_W'(TAPS_N);
    localparam logic [SUM_W-1:0] BINS_S = SUM_W'(BINS);
    localparam logic [SUM_W-1:0] TAP_MUL = SUM_W'(DLL_F);
    localparam logic [SUM_W-1:0] DLL_MUL = SUM_W'(DLL_F + 1);

    logic             in_range;
    logic [SUM_W-1:0] raw_sum;
    logic [FINE_W-1:0] fine_nxt;

    always_comb begin
        in_range = (in_dll < K_LIM) && (in_tap < I_LIM);
        // Tap i advances F bins, line k advances F+1 bins; wrap once.
        raw_sum  = (SUM_W'(in_tap) * TAP_MUL) + (SUM_W'(in_dll) * DLL_MUL);
        if (raw_sum >= BINS_S) begin
            fine_nxt = FINE_W'(raw_sum - BINS_S);
        end else begin
            fine_nxt = FINE_W'(raw_sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind   <= HK_IDLE;
            s1_fine   <= '0;
            s1_coarse <= '0;
        end else begin
            if (!in_vld) begin
                s1_kind <= HK_IDLE;
            end else if (in_range) begin
                s1_kind <= HK_HIT;
            end else begin
                s1_kind <= HK_FAULT;
            end
            s1_fine   <= fine_nxt;
            s1_coarse <= in_coarse;
        end
    end

endmodule

// File: rtl/tdc_enc_scale.sv
module tdc_enc_scale
    import tdc_enc_pkg::*;
#(
    parameter int TAPS_N   = 35,
    parameter int DLL_F    = 4,
    parameter int COARSE_W = 12,
    parameter int FINE_W   = 8,
    parameter int OUT_W    = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  hit_kind_e           s1_kind,
    input  logic [FINE_W-1:0]   s1_fine,
    input  logic [COARSE_W-1:0] s1_coarse,
    output logic                o_vld,
    output logic                o_err,
    output logic [OUT_W-1:0]    o_word
);
    localparam int BINS = int'(bins_per_period(TAPS_N, DLL_F));
    localparam logic [FINE_W-1:0] BIN_CONST = FINE_W'(BINS);

    // Constant multiply as a shift-add chain over the set bits of BINS.
    logic [FINE_W:0][OUT_W-1:0] part;
    assign part[0] = '0;

    for (genvar b = 0; b < FINE_W; b++) begin : g_mul
        if (BIN_CONST[b]) begin : g_add
            assign part[b+1] = part[b] + (OUT_W'(s1_coarse) << b);
        end else begin : g_skip
            assign part[b+1] = part[b];
        end
    end

    logic [OUT_W-1:0] word_nxt;
    assign word_nxt = part[FINE_W] + OUT_W'(s1_fine);

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_err  <= 1'b0;
            o_word <= '0;
        end else begin
            o_vld <= (s1_kind == HK_HIT);
            o_err <= (s1_kind == HK_FAULT);
            if (s1_kind == HK_HIT) begin
                o_word <= word_nxt;
            end
        end
    end

endmodule

// File: rtl/tdc_fine_encoder.sv
module tdc_fine_encoder
    import tdc_enc_pkg::*;
#(
    parameter int TAPS_N   = 35,
    parameter int DLL_F    = 4,
    parameter int COARSE_W = 12,
    parameter int K_W      = $clog2(DLL_F) + 1,
    parameter int I_W      = $clog2(TAPS_N) + 1,
    parameter int FINE_W   = $clog2(TAPS_N * DLL_F),
    parameter int OUT_W    = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_vld,
    input  logic [K_W-1:0]      hit_dll,
    input  logic [I_W-1:0]      hit_tap,
    input  logic [COARSE_W-1:0] hit_coarse,
    output logic                time_vld,
    output logic                time_err,
    output logic [OUT_W-1:0]    time_word
);
    hit_kind_e           s1_kind;
    logic [FINE_W-1:0]   s1_fine;
    logic [COARSE_W-1:0] s1_coarse;

    tdc_enc_bin_map #(
        .TAPS_N(TAPS_N), .DLL_F(DLL_F), .K_W(K_W), .I_W(I_W),
        .COARSE_W(COARSE_W), .FINE_W(FINE_W)
    ) u_map (
        .clk(clk), .rst(rst),
        .in_vld(hit_vld), .in_dll(hit_dll), .in_tap(hit_tap), .in_coarse(hit_coarse),
        .s1_kind(s1_kind), .s1_fine(s1_fine), .s1_coarse(s1_coarse)
    );

    tdc_enc_scale #(
        .TAPS_N(TAPS_N), .DLL_F(DLL_F), .COARSE_W(COARSE_W),
        .FINE_W(FINE_W), .OUT_W(OUT_W)
    ) u_scale (
        .clk(clk), .rst(rst),
        .s1_kind(s1_kind), .s1_fine(s1_fine), .s1_coarse(s1_coarse),
        .o_vld(time_vld), .o_err(time_err), .o_word(time_word)
    );

endmodule

// File: rtl/tdc_fine_encoder_chk.sv
module tdc_fine_encoder_chk #(
    parameter int TAPS_N = 35,
    parameter int DLL_F  = 4,
    parameter int K_W    = 3,
    parameter int I_W    = 7,
    parameter int OUT_W  = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_vld,
    input logic [K_W-1:0]   hit_dll,
    input logic [I_W-1:0]   hit_tap,
    input logic             time_vld,
    input logic             time_err,
    input logic [OUT_W-1:0] time_word
);
    localparam logic [K_W-1:0] K_LIM = K_W'(DLL_F);
    localparam logic [I_W-1:0] I_LIM = I_W'(TAPS_N);

    logic code_ok;
    assign code_ok = (hit_dll < K_LIM) && (hit_tap < I_LIM);

    assert_hit_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && code_ok) |-> ##2 (time_vld && !time_err));

    assert_fault_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_vld && !code_ok) |-> ##2 (time_err && !time_vld));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !hit_vld |-> ##2 (!time_vld && !time_err));

    assert_word_held_R7: assert property (@(posedge clk) disable iff (rst)
        !time_vld |-> $stable(time_word));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({time_vld, time_err}));

endmodule

bind tdc_fine_encoder tdc_fine_encoder_chk #(
    .TAPS_N(TAPS_N), .DLL_F(DLL_F), .K_W(K_W), .I_W(I_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst(rst), .hit_vld(hit_vld), .hit_dll(hit_dll), .hit_tap(hit_tap),
    .time_vld(time_vld), .time_err(time_err), .time_word(time_word)
);

// File: tb/tdc_fine_encoder_test.sv
`timescale 1ns/1ps
module tdc_fine_encoder_test;
    localparam int NA = 35, FA = 4, NB = 15, FB = 2, CW = 12;
    localparam int BA = NA * FA, BB = NB * FB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        va = 1'b0, vb = 1'b0;
    logic [2:0]  ka = '0;
    logic [6:0]  ia = '0;
    logic [1:0]  kb = '0;
    logic [4:0]  ib = '0;
    logic [CW-1:0] ca = '0, cb = '0;
    logic        tva, tea, tvb, teb;
    logic [19:0] twa;
    logic [16:0] twb;

    tdc_fine_encoder #(.TAPS_N(NA), .DLL_F(FA), .COARSE_W(CW)) uut (
        .clk(clk), .rst(rst), .hit_vld(va), .hit_dll(ka), .hit_tap(ia), .hit_coarse(ca),
        .time_vld(tva), .time_err(tea), .time_word(twa));

    tdc_fine_encoder #(.TAPS_N(NB), .DLL_F(FB), .COARSE_W(CW)) uut_b (
        .clk(clk), .rst(rst), .hit_vld(vb), .hit_dll(kb), .hit_tap(ib), .hit_coarse(cb),
        .time_vld(tvb), .time_err(teb), .time_word(twb));

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit rec  = 1'b0;
    int mk [2][2];   // kind per instance and slot: 0 idle, 1 hit, 2 fault
    int mt [2][2];
    int hold [2];
    bit seen_a [BA];
    bit seen_b [BB];

    function automatic int fine_of(int n, int f, int k, int i);
        return (i * f + k * (f + 1)) % (n * f);
    endfunction

    task automatic cmp(string tag, int d, bit av, bit ae, int aw);
        int  ek;
        bit  ev, ee;
        ek = mk[d][1];
        ev = (ek == 1);
        ee = (ek == 2);
        if (ev) hold[d] = mt[d][1];
        n_chk++;
        if (av !== ev || ae !== ee || aw != hold[d]) begin
            n_bad++;
            $display("FAIL %s%s: vld/err/word actual %0b/%0b/%0d expected %0b/%0b/%0d",
                     (d == 1) ? "R9+" : "", tag, av, ae, aw, ev, ee, hold[d]);
        end
        if (rec && av) begin
            if (d == 0 && (aw % BA) < BA) seen_a[aw % BA] = 1'b1;
            if (d == 1 && (aw % BB) < BB) seen_b[aw % BB] = 1'b1;
        end
    endtask

    task automatic push(int d, bit v, int k, int i, int c, int n, int f);
        mk[d][1] = mk[d][0];
        mt[d][1] = mt[d][0];
        if (!v)                  mk[d][0] = 0;
        else if (k >= f || i >= n) mk[d][0] = 2;
        else begin
            mk[d][0] = 1;
            mt[d][0] = c * n * f + fine_of(n, f, k, i);
        end
    endtask

    task automatic step(string tag, bit pva, int pka, int pia, int pca,
                        bit pvb, int pkb, int pib, int pcb);
        @(negedge clk);
        cmp(tag, 0, tva, tea, int'(twa));
        cmp(tag, 1, tvb, teb, int'(twb));
        push(0, pva, pka, pia, pca, NA, FA);
        push(1, pvb, pkb, pib, pcb, NB, FB);
        va = pva; ka = 3'(pka); ia = 7'(pia); ca = CW'(pca);
        vb = pvb; kb = 2'(pkb); ib = 5'(pib); cb = CW'(pcb);
    endtask

    task automatic idle(string tag, int cnt);
        for (int j = 0; j < cnt; j++) step(tag, 1'b0, 7, 127, 99, 1'b0, 3, 31, 77);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            hold[d] = 0;
            for (int s = 0; s < 2; s++) begin mk[d][s] = 0; mt[d][s] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        cmp("R1", 0, tva, tea, int'(twa));
        cmp("R1", 1, tvb, teb, int'(twb));
        rst = 1'b0;

        // R2/R6: exhaustive back-to-back sweep of every (k, i) pair
        rec = 1'b1;
        for (int s = 0; s < BA; s++)
            step("R2", 1'b1, s / NA, s % NA, 0, s < BB, (s / NB) % 4, s % NB, 0);
        idle("R6", 2);
        rec = 1'b0;

        // R4: coarse scaling including the all-ones count
        step("R4", 1'b1, 3, 34, 4095, 1'b1, 1, 14, 4095);
        step("R4", 1'b1, 0, 0, 1, 1'b1, 0, 0, 1);
        step("R4", 1'b1, 2, 17, 2047, 1'b1, 1, 7, 2048);
        step("R4", 1'b1, 1, 33, 100, 1'b1, 0, 13, 333);
        idle("R4", 2);

        // R7: out-of-range codes interleaved with good hits
        step("R7", 1'b1, 1, 5, 7, 1'b1, 1, 3, 7);
        step("R7", 1'b1, 4, 0, 9, 1'b1, 2, 0, 9);
        step("R7", 1'b1, 0, 35, 9, 1'b1, 0, 15, 9);
        step("R7", 1'b1, 7, 127, 9, 1'b1, 3, 31, 9);
        step("R7", 1'b1, 3, 34, 8, 1'b1, 1, 14, 8);
        step("R7", 1'b1, 4, 34, 8, 1'b1, 2, 14, 8);
        idle("R7", 2);

        // R8: strobe low with arbitrary code inputs
        step("R8", 1'b1, 2, 2, 55, 1'b1, 1, 1, 55);
        idle("R8", 4);

        // R5: isolated hit, then quiet cycles around its result
        step("R5", 1'b1, 1, 20, 3000, 1'b1, 1, 10, 3000);
        idle("R5", 3);

        // R6: alternating hits and gaps
        for (int j = 0; j < 8; j++)
            step("R6", (j % 2) == 0, j % 4, j * 4, j, (j % 2) == 0, j % 2, j, j);
        idle("R6", 3);

        // R3: coverage of every bin by the sweep
        begin
            int ca_n = 0, cb_n = 0;
            for (int b = 0; b < BA; b++) if (seen_a[b]) ca_n++;
            for (int b = 0; b < BB; b++) if (seen_b[b]) cb_n++;
            n_chk++;
            if (ca_n != BA) begin
                n_bad++;
                $display("FAIL R3: bins covered actual %0d expected %0d", ca_n, BA);
            end
            n_chk++;
            if (cb_n != BB) begin
                n_bad++;
                $display("FAIL R9+R3: bins covered actual %0d expected %0d", cb_n, BB);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run finished actual no expected yes");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule